// File: doc/BRIEF.md
# Multi-Path Programmable Oscillator Divider

This block divides a local-oscillator signal by a programmable ratio and emits a one-cycle pulse at the end of every division period, for use by a downstream phase comparator. Two oscillator inputs are present, a high-band one and a low-band one, both already squared to logic levels and sampled by the block clock, which runs well above either oscillator. The block counts rising edges of the selected input.

A band bit selects the input. With the high band selected, edges pass through a fixed divide-by-two stage ahead of a 16-bit counter, so one output period spans twice the programmed value in input edges. With the low band selected, a width bit picks between the 16-bit counter fed directly and a narrow 12-bit counting path with a much lower minimum ratio. Divisor and mode changes are held off until the current period ends, so every output period is a complete period of one configuration.

Top module: `lo_divider`

## Requirements
- R1: While `rst` is high and after it falls, `div_pulse` stays low until the first full division period of the configuration present at reset has been counted.
- R2: With `band_hi` = 1, `osc_hi` is used and one output period spans 2·N rising edges of `osc_hi`, N being the 16-bit divisor ratio.
- R3: With `band_hi` = 0 and `lo_wide` = 1, `osc_lo` is used and one output period spans N rising edges, N taken from all 16 bits of `div_word`.
- R4: With `band_hi` = 0 and `lo_wide` = 0, one output period spans N rising edges of `osc_lo`, N taken from `div_word[11:0]` only; bits 15..12 have no effect.
- R5: A 16-bit divisor field of zero means 65,536; a 12-bit field of zero means 4,096.
- R6: On the 16-bit paths a divisor from 1 to 255 acts as 256; on the 12-bit path a divisor from 1 to 3 acts as 4.
- R7: Changes of `band_hi`, `lo_wide` or `div_word` take effect only after the next output pulse; the period under way keeps its old length.
- R8: `div_pulse` is high for exactly one clock cycle, the cycle right after the clock edge at which the rising edge that completes the period is first sampled.
- R9: Edges on the input that is not selected do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples both oscillator inputs |
| rst | input | 1 | Synchronous reset, active high |
| osc_hi | input | 1 | High-band oscillator, squared |
| osc_lo | input | 1 | Low-band oscillator, squared |
| band_hi | input | 1 | 1 selects the high band with the divide-by-two stage |
| lo_wide | input | 1 | Low band only: 1 = 16-bit path, 0 = 12-bit path |
| div_word | input | 16 | Programmed divisor |
| div_pulse | output | 1 | One-cycle pulse per division period |

## Verification
A counter, halving flop or latched configuration that goes wrong shows at `div_pulse` as a pulse one or more edges early or late, or as a pulse that never comes. Such an error appears no later than the end of the period in which it happens, which is as short as four input edges on the narrow path and as long as 131,072 on the high band. The bench compares `div_pulse` on every clock against an edge-counting model, so a shift of a single cycle is caught at the pulse it affects.

// File: rtl/lodiv_pkg.sv
package lodiv_pkg;
  parameter int unsigned DIV_W      = 16;
  parameter int unsigned NARROW_W   = 12;
  parameter int unsigned WIDE_MIN   = 256;
  parameter int unsigned NARROW_MIN = 4;
  localparam int unsigned RATIO_W   = DIV_W + 1;

  typedef enum logic [1:0] {
    PATH_NARROW = 2'd0,
    PATH_WIDE   = 2'd1,
    PATH_HALVED = 2'd2
  } path_e;

  typedef struct packed {
    path_e            path;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic path_e pick_path(logic band_hi, logic lo_wide);
    if (band_hi) return PATH_HALVED;
    if (lo_wide) return PATH_WIDE;
    return PATH_NARROW;
  endfunction

  // Counter strobes in one period, after zero-encoding and clamping.
  function automatic logic [RATIO_W-1:0] strobes_per_period(cfg_t c);
    logic [RATIO_W-1:0] n;
    n = '0;
    if (c.path == PATH_NARROW) begin
      n[NARROW_W-1:0] = c.div[NARROW_W-1:0];
      if (n == '0) n[NARROW_W] = 1'b1;
      else if (n < RATIO_W'(NARROW_MIN)) n = RATIO_W'(NARROW_MIN);
    end else begin
      n[DIV_W-1:0] = c.div;
      if (n == '0) n[DIV_W] = 1'b1;
      else if (n < RATIO_W'(WIDE_MIN)) n = RATIO_W'(WIDE_MIN);
    end
    return n;
  endfunction

  function automatic logic [DIV_W-1:0] reload_of(cfg_t c);
    logic [RATIO_W-1:0] m;
    m = strobes_per_period(c) - RATIO_W'(1);
    return m[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/lodiv_edge.sv
module lodiv_edge #(
  parameter int unsigned N_IN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] lvl,
  output logic [N_IN-1:0] rise
);
  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q;

    // R8: an edge event never lasts two cycles
    p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/lodiv_halve.sv
module lodiv_halve (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rise,
  output logic strobe
);
  logic odd_q;

  always_ff @(posedge clk) begin
    if (rst)            odd_q <= 1'b0;
    else if (en & rise) odd_q <= ~odd_q;
  end

  assign strobe = en & rise & odd_q;

  // R2: after each forwarded strobe the stage restarts on an even count
  p_halve_restart_r2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !odd_q);
endmodule

// File: rtl/lodiv_count.sv
module lodiv_count
  import lodiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  cfg_t cfg_next,
  output cfg_t cfg_q,
  output logic tc,
  output logic pulse
);
  logic [DIV_W-1:0] cnt_q;

  assign tc = strobe && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_next;
      cnt_q <= reload_of(cfg_next);
      pulse <= 1'b0;
    end else begin
      pulse <= tc;
      if (tc) begin
        cfg_q <= cfg_next;
        cnt_q <= reload_of(cfg_next);
      end else if (strobe) begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end

  // R7: configuration is held between terminal counts
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !tc |=> $stable(cfg_q));
  // R5: the count never exceeds the period of the latched configuration
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= reload_of(cfg_q));
  // R6: a pulse coincides with a full reload for the new configuration
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (cnt_q == reload_of(cfg_q)));
  // R8: one-cycle pulse
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/lo_divider.sv
module lo_divider
  import lodiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_hi,
  input  logic             osc_lo,
  input  logic             band_hi,
  input  logic             lo_wide,
  input  logic [DIV_W-1:0] div_word,
  output logic             div_pulse
);
  localparam int unsigned LANE_HI = 1;
  localparam int unsigned LANE_LO = 0;

  cfg_t       cfg_in;
  cfg_t       cfg_q;
  logic [1:0] rise;
  logic       hi_en;
  logic       hi_strobe;
  logic       cnt_strobe;
  logic       tc;

  always_comb begin
    cfg_in.path = pick_path(band_hi, lo_wide);
    cfg_in.div  = div_word;
  end

  lodiv_edge #(.N_IN(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({osc_hi, osc_lo}),
    .rise (rise)
  );

  assign hi_en = (cfg_q.path == PATH_HALVED);

  lodiv_halve u_halve (
    .clk    (clk),
    .rst    (rst),
    .en     (hi_en),
    .rise   (rise[LANE_HI]),
    .strobe (hi_strobe)
  );

  assign cnt_strobe = hi_en ? hi_strobe : rise[LANE_LO];

  lodiv_count u_count (
    .clk      (clk),
    .rst      (rst),
    .strobe   (cnt_strobe),
    .cfg_next (cfg_in),
    .cfg_q    (cfg_q),
    .tc       (tc),
    .pulse    (div_pulse)
  );

  // R9: a period only ends on an edge of the selected input
  p_tc_on_active_edge_r9: assert property (@(posedge clk) disable iff (rst)
    tc |-> (hi_en ? rise[LANE_HI] : rise[LANE_LO]));
endmodule

// File: tb/lo_divider_bench.sv
module lo_divider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_hi = 1'b0;
  logic        osc_lo = 1'b0;
  logic        band_hi = 1'b0;
  logic        lo_wide = 1'b0;
  logic [15:0] div_word = 16'h0000;
  logic        div_pulse;

  always #2 clk = ~clk;

  lo_divider u_lo_divider (
    .clk(clk), .rst(rst), .osc_hi(osc_hi), .osc_lo(osc_lo),
    .band_hi(band_hi), .lo_wide(lo_wide), .div_word(div_word),
    .div_pulse(div_pulse)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;

  // requested configuration, applied to the ports at the next step
  bit          want_bh = 0;
  bit          want_lw = 0;
  logic [15:0] want_div = 16'h0000;
  string       cur_tag = "R1";

  // model state
  bit last_hi = 0, last_lo = 0, act_bh = 0, prev_exp = 0;
  int edges = 0, target = 0;

  function automatic int period_edges(bit bh, bit lw, int d);
    int v;
    if (!bh && !lw) begin
      v = d % 4096;
      if (v == 0) v = 4096;
      if (v < 4) v = 4;
      return v;
    end
    v = d;
    if (v == 0) v = 65536;
    if (v < 256) v = 256;
    return bh ? 2 * v : v;
  endfunction

  task automatic step(bit h, bit l);
    item_t it;
    bit rh, rl, e;
    @(negedge clk);
    band_hi  = want_bh;
    lo_wide  = want_lw;
    div_word = want_div;
    osc_hi   = h;
    osc_lo   = l;
    rh = h & !last_hi;
    rl = l & !last_lo;
    last_hi = h;
    last_lo = l;
    if (act_bh ? rh : rl) edges++;
    e = (edges == target);
    if (e) begin
      edges  = 0;
      act_bh = want_bh;
      target = period_edges(want_bh, want_lw, int'(want_div));
    end
    it.exp = e;
    it.tag = prev_exp ? "R8" : cur_tag;
    prev_exp = e;
    q.push_back(it);
  endtask

  task automatic run(int cycles, int hi_half, int lo_half);
    for (int k = 0; k < cycles; k++) begin
      bit h, l;
      h = (hi_half == 0) ? 1'b0 : (((k / hi_half) % 2) == 1);
      l = (lo_half == 0) ? 1'b0 : (((k / lo_half) % 2) == 1);
      step(h, l);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // monitor: compares the output after each edge with the queued expectation
  initial begin
    forever begin
      item_t it;
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        it = q.pop_front();
        vectors++;
        if (div_pulse !== it.exp) begin
          miscompares++;
          $display("FAIL %s: div_pulse actual=%0b expected=%0b at %0t",
                   it.tag, div_pulse, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset, narrow path with divisor 7 and idle inputs
    want_bh = 0; want_lw = 0; want_div = 16'h1007;
    band_hi = 0; lo_wide = 0; div_word = 16'h1007;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      vectors++;
      if (div_pulse !== 1'b0) begin
        miscompares++;
        $display("FAIL R1: div_pulse in reset actual=%0b expected=0", div_pulse);
      end
    end
    @(negedge clk);
    rst = 1'b0;
    act_bh = 0;
    edges  = 0;
    target = period_edges(0, 0, 16'h1007);
    cur_tag = "R1"; run(20, 3, 1);
    // R4: upper bits ignored, ratio 7, high band toggling meanwhile
    cur_tag = "R4"; run(60, 3, 1);
    // R7 then R6: divisor 2 requested mid-period, clamped to 4
    want_div = 16'd2;
    cur_tag = "R7"; run(9, 1, 1);
    cur_tag = "R6"; run(40, 2, 1);
    // R3: 16-bit low-band path, ratio 300
    want_lw = 1; want_div = 16'd300;
    cur_tag = "R3"; run(1300, 2, 1);
    // R9: selected low input idle while high input toggles
    cur_tag = "R9"; run(600, 1, 0);
    // R6: 16-bit clamp to 256
    want_div = 16'd10;
    cur_tag = "R6"; run(1100, 0, 2);
    // R2: high band with divide-by-two, ratio 260 -> 520 edges
    want_bh = 1; want_div = 16'd260;
    cur_tag = "R2"; run(2400, 1, 1);
    // R9: high band selected, only low input moving
    cur_tag = "R9"; run(300, 0, 1);
    // R7: change requested mid-period of the high band
    want_div = 16'd256;
    cur_tag = "R7"; run(1200, 1, 3);
    // R5: narrow path zero field -> 4096
    want_bh = 0; want_lw = 0; want_div = 16'hF000;
    cur_tag = "R5"; run(9300, 1, 1);
    // R5: wide path zero field -> 65536
    want_lw = 1; want_div = 16'h0000;
    cur_tag = "R5"; run(139400, 0, 1);
    repeat (3) @(posedge clk);
    #1;
    summary();
  end
endmodule